// File: doc/BRIEF.md
# Burst Initiator Sequencer for a Registered Shared Bus

This block runs one burst transaction at a time as the initiator on a shared parallel bus with registered signalling. A command on the local side is accepted only while the block is idle. The bus then sees three things in turn. First comes one address cycle. Next comes one attribute cycle that packs a 36-bit descriptor over the address/data lines and the command/byte-enable lines together. Last comes a claim window in which a target answers with a device-select. The burst length is fixed by the byte count before the transaction starts. After the claim, data moves on every cycle with no initiator wait states. The frame signal is released ahead of the end so that the target learns of the end in time.

Bus inputs reach the sequencing logic only through a register stage, and every bus output comes from state. The earliest reaction to a bus event therefore lands two cycles after it. A target may cut a burst short by signalling stop. The burst then ends on the last word before a 128-byte address boundary that the block can still reach. If no target claims by the last decode slot, the transaction ends with a master-abort status.

Local streams follow these rules. The write stream is valid/ready, and the source must hold `wr_valid` high whenever `wr_ready` is high, because the bus cannot be stalled. The read stream has no ready, and the sink must take every `rd_valid` beat.

Top module: `bus_burst_initiator`

## Requirements
- R1: `cmd_ready` is high exactly while the block is idle. A command is taken on a clock edge with `cmd_valid` and `cmd_ready` both high. Out of reset the block is idle with `frame_n` and `irdy_n` high, `ad_oe` low and `done` low.
- R2: The cycle after acceptance is the address cycle. In it `frame_n` is low, `irdy_n` is high, `ad_oe` is high, `ad_out` equals the command address and `cbe_n` carries the command code: 4'b0110 for a read and 4'b0111 for a write.
- R3: The next cycle is the single attribute cycle. In it `ad_out` = {tag[3:0], byte_count[11:0], requester_id[15:0]} and `cbe_n` = {status[2:0], tag[4]}, which puts the requester ID in the lowest bits, then the byte count, then the tag, then the status bits.
- R4: Claim slot 1 is the cycle after the attribute cycle. If `devsel_n` first goes low in slot s (1 to 5) and stays low, the first data phase is slot s+2.
- R5: If `devsel_n` stays high through slots 1 to 5, no data phase occurs. In slot 7 `frame_n` and `irdy_n` are high and `done` pulses with status 2 (master abort) and a word count of 0.
- R6: The burst has N = byte_count/4 words, with byte_count a multiple of 4 and N at least 2. The N data phases occupy consecutive cycles. `irdy_n` is low from slot 1 through the final data phase.
- R7: `frame_n` stays low from the address cycle until the final data phase minus two. It is high in the last two data phases.
- R8: For a write, `wr_ready` is high in the cycle before each data phase and in no other cycle. Word i taken from the stream is driven on `ad_out`, with `ad_oe` high and `cbe_n` = 4'b0000, in data phase i.
- R9: For a read, `ad_oe` is low from slot 1 onward. The `ad_in` value of each data phase comes out on `rd_data` with `rd_valid` high in the following cycle.
- R10: When `stop_n` is low in data phase k, the final phase becomes the smallest j >= k+3 for which address + 4*(j+1) is a multiple of 128, provided j is below the planned final index. The status is then 1 (disconnect). A low `stop_n` outside data phases is ignored.
- R11: One cycle after the final data phase, `done` is high for exactly one cycle, together with `cmd_ready`. The status is 0 for a full burst and the word count is the number of data phases run. `irdy_n` and `frame_n` are high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_write | input | 1 | 1 = write burst, 0 = read burst |
| cmd_addr | input | 32 | Word-aligned start address |
| cmd_rid | input | 16 | Requester identity (bus, device, function) |
| cmd_tag | input | 5 | Transaction tag |
| cmd_bcnt | input | 12 | Burst byte count |
| cmd_attr_st | input | 3 | Extra attribute status bits |
| wr_valid | input | 1 | Write word present |
| wr_ready | output | 1 | Write word taken this edge |
| wr_data | input | 32 | Write word |
| rd_valid | output | 1 | Read word present (no back-pressure) |
| rd_data | output | 32 | Read word |
| done | output | 1 | One-cycle end-of-transaction pulse |
| done_status | output | 2 | 0 normal, 1 disconnect, 2 master abort |
| done_words | output | 10 | Data phases completed |
| frame_n | output | 1 | Active-low frame |
| irdy_n | output | 1 | Active-low initiator ready |
| ad_out | output | 32 | Address/data lines driven by the block |
| ad_oe | output | 1 | Drive enable for ad_out |
| ad_in | input | 32 | Address/data lines as seen on the bus |
| cbe_n | output | 4 | Command/byte-enable lines |
| devsel_n | input | 1 | Active-low target claim |
| trdy_n | input | 1 | Active-low target ready |
| stop_n | input | 1 | Active-low target stop |

## Verification
The assertions check on every cycle the relations that hold regardless of timing choices. The command side is closed while the bus is busy, and frame is released only with initiator ready still asserted. Initiator ready rises only together with the done pulse, the done pulse is a single cycle, and every write-ready cycle is followed by a driven data phase. Read-valid never coincides with the block driving the lines. The scenario sweep is the only way to show where things land: the exact slot of the first data phase for each claim slot, the cycle in which frame rises, the packed attribute word, the recomputed end of a disconnected burst near a 128-byte boundary, and the data order in both directions.

// File: rtl/bbi_pkg.sv
package bbi_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_ATTR, PH_CLAIM, PH_DATA
  } phase_e;

  typedef enum logic [1:0] {
    END_OK    = 2'd0,
    END_DISC  = 2'd1,
    END_ABORT = 2'd2
  } end_e;

  localparam logic [3:0] CODE_RD = 4'b0110;
  localparam logic [3:0] CODE_WR = 4'b0111;
endpackage

// File: rtl/bbi_pin_reg.sv
module bbi_pin_reg #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_n,
  output logic [W-1:0] q
);
  // one register stage between bus pins and the sequencing logic
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= ~pin_n;
  end
endmodule

// File: rtl/bbi_attr_pack.sv
module bbi_attr_pack #(
  parameter int AD_W   = 32,
  parameter int CBE_W  = 4,
  parameter int RID_W  = 16,
  parameter int BCNT_W = 12,
  parameter int TAG_W  = 5,
  parameter int ST_W   = 3
) (
  input  logic [RID_W-1:0]  rid,
  input  logic [BCNT_W-1:0] bcnt,
  input  logic [TAG_W-1:0]  tag,
  input  logic [ST_W-1:0]   st,
  output logic [AD_W-1:0]   attr_ad,
  output logic [CBE_W-1:0]  attr_cbe
);
  localparam int ATTR_W = RID_W + BCNT_W + TAG_W + ST_W;
  localparam int LINE_W = AD_W + CBE_W;

  logic [LINE_W-1:0] word;

  // low to high: identity, byte count, tag, status; pad if lines are wider
  always_comb begin
    word = LINE_W'({st, tag, bcnt, rid});
  end

  assign attr_ad  = word[AD_W-1:0];
  assign attr_cbe = word[LINE_W-1:AD_W];

  if (ATTR_W > LINE_W) begin : g_width_bad
    initial $display("bbi_attr_pack: attribute wider than bus lines");
  end
endmodule

// File: rtl/bbi_disc_calc.sv
module bbi_disc_calc #(
  parameter int IDX_W       = 10,
  parameter int BOUND_WORDS = 32
) (
  input  logic [$clog2(BOUND_WORDS)-1:0] base_lo,
  input  logic [IDX_W-1:0]               cur,
  output logic [IDX_W:0]                 stop_idx
);
  localparam int BND_SH = $clog2(BOUND_WORDS);

  logic [BND_SH-1:0] pos;
  logic [BND_SH-1:0] gap;

  // earliest reachable phase is cur+2; run on to the word before a boundary
  always_comb begin
    pos      = base_lo + BND_SH'(cur) + BND_SH'(2);
    gap      = BND_SH'(BOUND_WORDS - 1) - pos;
    stop_idx = (IDX_W+1)'(cur) + (IDX_W+1)'(2) + (IDX_W+1)'(gap);
  end
endmodule

// File: rtl/bus_burst_initiator.sv
module bus_burst_initiator
  import bbi_pkg::*;
#(
  parameter int AD_W        = 32,
  parameter int CBE_W       = 4,
  parameter int RID_W       = 16,
  parameter int BCNT_W      = 12,
  parameter int TAG_W       = 5,
  parameter int ST_W        = 3,
  parameter int BOUND_BYTES = 128,
  parameter int LAST_SLOT   = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cmd_valid,
  output logic                          cmd_ready,
  input  logic                          cmd_write,
  input  logic [AD_W-1:0]               cmd_addr,
  input  logic [RID_W-1:0]              cmd_rid,
  input  logic [TAG_W-1:0]              cmd_tag,
  input  logic [BCNT_W-1:0]             cmd_bcnt,
  input  logic [ST_W-1:0]               cmd_attr_st,
  input  logic                          wr_valid,
  output logic                          wr_ready,
  input  logic [AD_W-1:0]               wr_data,
  output logic                          rd_valid,
  output logic [AD_W-1:0]               rd_data,
  output logic                          done,
  output logic [1:0]                    done_status,
  output logic [BCNT_W-$clog2(AD_W/8)-1:0] done_words,
  output logic                          frame_n,
  output logic                          irdy_n,
  output logic [AD_W-1:0]               ad_out,
  output logic                          ad_oe,
  input  logic [AD_W-1:0]               ad_in,
  output logic [CBE_W-1:0]              cbe_n,
  input  logic                          devsel_n,
  input  logic                          trdy_n,
  input  logic                          stop_n
);
  localparam int WORD_SH     = $clog2(AD_W/8);
  localparam int IDX_W       = BCNT_W - WORD_SH;
  localparam int BOUND_WORDS = BOUND_BYTES / (AD_W/8);
  localparam int BND_SH      = $clog2(BOUND_WORDS);
  localparam int SLOT_W      = $clog2(LAST_SLOT + 2) + 1;

  phase_e             state;
  end_e               status_q;
  logic [SLOT_W-1:0]  slot;
  logic [IDX_W-1:0]   widx, lastw, words_q;
  logic               disc, is_wr, in_data_q, done_q;
  logic [AD_W-1:0]    addr_q, ad_q, rd_data_q;
  logic               rd_valid_q;
  logic [RID_W-1:0]   rid_q;
  logic [BCNT_W-1:0]  bcnt_q;
  logic [TAG_W-1:0]   tag_q;
  logic [ST_W-1:0]    st_q;
  logic               devsel_q, stop_q, go_data;
  logic [AD_W-1:0]    attr_ad;
  logic [CBE_W-1:0]   attr_cbe;
  logic [IDX_W:0]     stop_idx;

  bbi_pin_reg #(.W(2)) u_pins (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_n ({devsel_n, stop_n}),
    .q     ({devsel_q, stop_q})
  );

  bbi_attr_pack #(
    .AD_W(AD_W), .CBE_W(CBE_W), .RID_W(RID_W),
    .BCNT_W(BCNT_W), .TAG_W(TAG_W), .ST_W(ST_W)
  ) u_attr (
    .rid      (rid_q),
    .bcnt     (bcnt_q),
    .tag      (tag_q),
    .st       (st_q),
    .attr_ad  (attr_ad),
    .attr_cbe (attr_cbe)
  );

  bbi_disc_calc #(.IDX_W(IDX_W), .BOUND_WORDS(BOUND_WORDS)) u_disc (
    .base_lo  (addr_q[WORD_SH +: BND_SH]),
    .cur      (widx),
    .stop_idx (stop_idx)
  );

  // a claim seen in slot s is visible here in slot s+1; data starts at s+2
  assign go_data  = (state == PH_CLAIM) && devsel_q && (slot >= SLOT_W'(2));
  assign wr_ready = is_wr && (go_data || (state == PH_DATA && widx != lastw));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= PH_IDLE;
      status_q   <= END_OK;
      slot       <= '0;
      widx       <= '0;
      lastw      <= '0;
      words_q    <= '0;
      disc       <= 1'b0;
      is_wr      <= 1'b0;
      in_data_q  <= 1'b0;
      done_q     <= 1'b0;
      addr_q     <= '0;
      ad_q       <= '0;
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
      rid_q      <= '0;
      bcnt_q     <= '0;
      tag_q      <= '0;
      st_q       <= '0;
    end else begin
      done_q     <= 1'b0;
      in_data_q  <= (state == PH_DATA);
      rd_valid_q <= (state == PH_DATA) && !is_wr && !trdy_n;
      rd_data_q  <= ad_in;
      if (wr_ready && wr_valid) ad_q <= wr_data;
      unique case (state)
        PH_IDLE: if (cmd_valid) begin
          is_wr  <= cmd_write;
          addr_q <= cmd_addr;
          rid_q  <= cmd_rid;
          bcnt_q <= cmd_bcnt;
          tag_q  <= cmd_tag;
          st_q   <= cmd_attr_st;
          lastw  <= cmd_bcnt[BCNT_W-1:WORD_SH] - IDX_W'(1);
          disc   <= 1'b0;
          state  <= PH_ADDR;
        end
        PH_ADDR: state <= PH_ATTR;
        PH_ATTR: begin
          state <= PH_CLAIM;
          slot  <= SLOT_W'(1);
          widx  <= '0;
        end
        PH_CLAIM: begin
          if (go_data) begin
            state <= PH_DATA;
          end else if (slot == SLOT_W'(LAST_SLOT + 1)) begin
            state    <= PH_IDLE;
            done_q   <= 1'b1;
            status_q <= END_ABORT;
            words_q  <= '0;
          end else begin
            slot <= slot + SLOT_W'(1);
          end
        end
        PH_DATA: begin
          if (widx == lastw) begin
            state    <= PH_IDLE;
            done_q   <= 1'b1;
            status_q <= disc ? END_DISC : END_OK;
            words_q  <= widx + IDX_W'(1);
          end else begin
            widx <= widx + IDX_W'(1);
            if (in_data_q && stop_q && (stop_idx < {1'b0, lastw})) begin
              lastw <= stop_idx[IDX_W-1:0];
              disc  <= 1'b1;
            end
          end
        end
        default: state <= PH_IDLE;
      endcase
    end
  end

  assign cmd_ready   = (state == PH_IDLE);
  assign done        = done_q;
  assign done_status = status_q;
  assign done_words  = words_q;
  assign rd_valid    = rd_valid_q;
  assign rd_data     = rd_data_q;

  always_comb begin
    frame_n = 1'b1;
    irdy_n  = 1'b1;
    ad_oe   = 1'b0;
    ad_out  = ad_q;
    cbe_n   = '1;
    unique case (state)
      PH_ADDR: begin
        frame_n = 1'b0;
        ad_oe   = 1'b1;
        ad_out  = addr_q;
        cbe_n   = CBE_W'(is_wr ? CODE_WR : CODE_RD);
      end
      PH_ATTR: begin
        frame_n = 1'b0;
        ad_oe   = 1'b1;
        ad_out  = attr_ad;
        cbe_n   = attr_cbe;
      end
      PH_CLAIM: begin
        frame_n = 1'b0;
        irdy_n  = 1'b0;
        ad_oe   = is_wr;
        cbe_n   = '0;
      end
      PH_DATA: begin
        frame_n = !((widx + IDX_W'(1)) < lastw);
        irdy_n  = 1'b0;
        ad_oe   = is_wr;
        cbe_n   = '0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bbi_chk.sv
module bbi_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_ready,
  input logic frame_n,
  input logic irdy_n,
  input logic ad_oe,
  input logic done,
  input logic wr_ready,
  input logic rd_valid
);
  // R1
  idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (frame_n && irdy_n));

  // R2
  addr_cycle_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_n) |-> (ad_oe && irdy_n));

  // R7
  frame_early_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(frame_n) && !done) |-> !irdy_n);

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  irdy_release_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irdy_n) |-> done);

  // R8
  write_pop_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |=> (!irdy_n && ad_oe));

  // R9
  read_beat_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !ad_oe);
endmodule

bind bus_burst_initiator bbi_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_ready (cmd_ready),
  .frame_n   (frame_n),
  .irdy_n    (irdy_n),
  .ad_oe     (ad_oe),
  .done      (done),
  .wr_ready  (wr_ready),
  .rd_valid  (rd_valid)
);

// File: tb/sim_bus_burst_initiator.sv
module sim_bus_burst_initiator;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_ready, cmd_write = 1'b0;
  logic [31:0] cmd_addr = '0;
  logic [15:0] cmd_rid = '0;
  logic [4:0]  cmd_tag = '0;
  logic [11:0] cmd_bcnt = '0;
  logic [2:0]  cmd_attr_st = '0;
  logic        wr_valid = 1'b1, wr_ready;
  logic [31:0] wr_data = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        done;
  logic [1:0]  done_status;
  logic [9:0]  done_words;
  logic        frame_n, irdy_n, ad_oe;
  logic [31:0] ad_out;
  logic [31:0] ad_in = '0;
  logic [3:0]  cbe_n;
  logic        devsel_n = 1'b1, trdy_n = 1'b1, stop_n = 1'b1;

  int total = 0;
  int bad   = 0;
  int id    = 0;

  bus_burst_initiator u0 (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_rid(cmd_rid), .cmd_tag(cmd_tag),
    .cmd_bcnt(cmd_bcnt), .cmd_attr_st(cmd_attr_st),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .done(done), .done_status(done_status), .done_words(done_words),
    .frame_n(frame_n), .irdy_n(irdy_n), .ad_out(ad_out), .ad_oe(ad_oe),
    .ad_in(ad_in), .cbe_n(cbe_n),
    .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] wpat(input int tid, input int i);
    return 32'hA500_0000 ^ (32'(tid) << 12) ^ 32'(i);
  endfunction

  function automatic logic [31:0] rpat(input int tid, input int i);
    return 32'h5A00_0000 ^ (32'(tid) << 12) ^ 32'(i * 3);
  endfunction

  task automatic run_txn(input bit wr, input logic [31:0] addr, input int n,
                         input int s, input int stopk);
    bit   abort;
    int   d0, last, fin, tdone, pops, j;
    logic [1:0] exp_st;
    logic frame_exp, rdy_exp, rv_exp, stop_now;
    id++;
    abort  = (s > 5);
    d0     = s + 2;
    last   = n - 1;
    exp_st = abort ? 2'd2 : 2'd0;
    if (!abort && stopk >= 0) begin
      j = stopk + 3;
      while ((((addr >> 2) + 32'(j) + 1) % 32) != 0) j++;
      if (j < last) begin
        last   = j;
        exp_st = 2'd1;
      end
    end
    fin   = d0 + last;
    tdone = abort ? 7 : fin + 1;
    pops  = 0;

    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 ready when idle", 32'(cmd_ready), 32'd1);
    cmd_write   = wr;
    cmd_addr    = addr;
    cmd_rid     = 16'h1234 ^ 16'(id);
    cmd_tag     = 5'(id);
    cmd_attr_st = 3'(id * 5);
    cmd_bcnt    = 12'(n * 4);
    cmd_valid   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    // address cycle
    chk(frame_n == 1'b0 && irdy_n == 1'b1 && ad_oe == 1'b1, "R2 address cycle controls",
        {29'd0, frame_n, irdy_n, ad_oe}, 32'b001);
    chk(ad_out == addr, "R2 address value", ad_out, addr);
    chk(cbe_n == (wr ? 4'b0111 : 4'b0110), "R2 command code", 32'(cbe_n),
        32'(wr ? 4'b0111 : 4'b0110));
    chk(cmd_ready == 1'b0, "R1 busy not ready", 32'(cmd_ready), 32'd0);
    @(posedge clk);
    @(negedge clk);
    // attribute cycle
    chk(ad_out == {cmd_tag[3:0], cmd_bcnt, cmd_rid}, "R3 attribute lines", ad_out,
        {cmd_tag[3:0], cmd_bcnt, cmd_rid});
    chk(cbe_n == {cmd_attr_st, cmd_tag[4]}, "R3 attribute cbe", 32'(cbe_n),
        32'({cmd_attr_st, cmd_tag[4]}));
    chk(frame_n == 1'b0 && irdy_n == 1'b1, "R3 attribute controls",
        {30'd0, frame_n, irdy_n}, 32'b01);

    for (int t = 1; t <= tdone + 1; t++) begin
      @(posedge clk);
      @(negedge clk);
      if (t < tdone) begin
        chk(irdy_n == 1'b0, "R6 irdy asserted through burst", 32'(irdy_n), 32'd0);
        frame_exp = abort ? 1'b0 : (t >= fin - 1);
        chk(frame_n == frame_exp, "R7 frame timing", 32'(frame_n), 32'(frame_exp));
        chk(done == 1'b0, "R11 no early done", 32'(done), 32'd0);
      end else if (t == tdone) begin
        chk(done == 1'b1, abort ? "R5 abort done" : "R11 done pulse", 32'(done), 32'd1);
        chk(done_status == exp_st, abort ? "R5 abort status" : "R10 R11 end status",
            32'(done_status), 32'(exp_st));
        chk(done_words == 10'(abort ? 0 : last + 1), "R11 word count",
            32'(done_words), 32'(abort ? 0 : last + 1));
        chk(irdy_n && frame_n && cmd_ready, "R11 bus released and ready",
            {29'd0, irdy_n, frame_n, cmd_ready}, 32'b111);
      end else begin
        chk(done == 1'b0, "R11 done single cycle", 32'(done), 32'd0);
      end

      if (wr) begin
        rdy_exp = !abort && t >= d0 - 1 && t <= fin - 1;
        chk(wr_ready == rdy_exp, "R8 write ready timing", 32'(wr_ready), 32'(rdy_exp));
        if (!abort && t >= d0 && t <= fin) begin
          chk(ad_out == wpat(id, t - d0),
              (t == d0) ? "R4 first data phase slot" : "R8 write word order",
              ad_out, wpat(id, t - d0));
          chk(ad_oe == 1'b1 && cbe_n == 4'b0000, "R8 write drive",
              {27'd0, ad_oe, cbe_n}, 32'h10);
        end
      end else begin
        rv_exp = !abort && t >= d0 + 1 && t <= fin + 1;
        chk(rd_valid == rv_exp, (t == d0 + 1) ? "R4 first read beat slot" : "R9 read valid timing",
            32'(rd_valid), 32'(rv_exp));
        if (rv_exp)
          chk(rd_data == rpat(id, t - 1 - d0), "R9 read data", rd_data, rpat(id, t - 1 - d0));
        if (t < tdone)
          chk(ad_oe == 1'b0, "R9 lines released on read", 32'(ad_oe), 32'd0);
      end

      // target model drives this cycle
      devsel_n = !(!abort && t >= s && t <= fin);
      trdy_n   = !(!abort && t >= d0 && t <= fin);
      ad_in    = (!wr && !abort && t >= d0 && t <= fin) ? rpat(id, t - d0) : 32'h0;
      if (stopk >= 0) stop_now = !abort && (t == d0 + stopk);
      else            stop_now = (t == (abort ? 2 : s));
      stop_n   = !stop_now;
      wr_data  = wpat(id, pops);
      if (wr_ready) pops++;
    end
    devsel_n = 1'b1;
    trdy_n   = 1'b1;
    stop_n   = 1'b1;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=finish", WATCHDOG);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] addrs [3];
    int          sizes [6];
    addrs = '{32'h1000_0000, 32'h2000_0070, 32'h3000_00F8};
    sizes = '{2, 3, 4, 6, 8, 40};
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready && frame_n && irdy_n, "R1 reset idle", {29'd0, cmd_ready, frame_n, irdy_n}, 32'b111);
    chk(!ad_oe && !done && !rd_valid && !wr_ready, "R1 reset outputs quiet",
        {28'd0, ad_oe, done, rd_valid, wr_ready}, 32'd0);

    for (int a = 0; a < 3; a++)
      for (int w = 0; w < 2; w++)
        for (int s = 1; s <= 6; s++)
          for (int z = 0; z < 6; z++) begin
            if (s == 6) begin
              run_txn(w[0], addrs[a], sizes[z], s, -1);   // R5 no claim
            end else begin
              for (int k = -1; k <= 7 && k < sizes[z]; k++)
                run_txn(w[0], addrs[a], sizes[z], s, k);  // R10 stop sweep
              if (sizes[z] > 8)
                run_txn(w[0], addrs[a], sizes[z], s, sizes[z] - 1);
            end
          end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule